// File: doc/BRIEF.md
# Programmed-I/O Window Decoder and Device Router

This block takes single programmed-I/O requests from a host port and works out which of five address windows each one falls in. The windows are the command and control register blocks of two disk channels, plus one bus-master register block. Every window starts at a base that software can reprogram and has a fixed size set by a parameter. For each accepted request the block records the window kind, the channel and the offset inside the window, and makes them visible on the decode outputs.

Command-block and control-block accesses go to one of four attached devices. The device number is the channel number times two plus a per-channel select bit. The block latches that select bit when a byte write reaches the select register of a command window. A device that is absent reads as zero and ignores writes. A 32-bit access to the data register is cut into two 16-bit device transfers, low half first, and the host request stays open until both halves are done. Requests to the bus-master window are decoded and acknowledged here. The register contents of that window live elsewhere.

Top module: `pio_window_router`

## Requirements
- R1: An address hits a window when base <= address < base + size. The offset is address minus base. dec_kind gives the window kind, encoded 0 for no window, 1 for command, 2 for control and 3 for bus-master. The defaults are command size 8, control size 4 and bus-master size 16.
- R2: When windows overlap, the first one in this order wins: primary command, primary control, secondary command, secondary control, bus-master. cfg_idx numbers the windows 0 to 4 in that same order.
- R3: In the bus-master window, an offset below BM_CH1 (default 8) reports channel 0 on dec_chan. Any other offset reports channel 1.
- R4: A base write through cfg_we/cfg_idx/cfg_base has an effect only when cfg_base is nonzero. A zero value leaves the base unchanged.
- R5: While io_en is low, every request completes with h_rdata 0 and h_err 0. It causes no device transfer and leaves the select bits unchanged.
- R6: A byte write (h_size 0) to command-window offset 6 loads that channel's select bit from data bit 4. Both select bits are 0 after reset.
- R7: The target device is channel*2 + select bit. A select write uses its new bit right away. A request to an absent device completes with no transfer, and a read returns 0.
- R8: While dv_valid is high and dv_ready is low, dv_valid, dv_dev, dv_off and dv_wdata hold steady.
- R9: Command-window offset 0 is the data register. A 16-bit access (h_size 1) makes one transfer. A 32-bit access (h_size 2) makes two transfers at the same offset: first h_wdata[15:0], then h_wdata[31:16]. A 32-bit read returns {second, first}.
- R10: A byte access to the data register, or a non-byte access to any other command or control register, completes with h_err set and makes no transfer.
- R11: An address outside every window completes with h_err set and no transfer.
- R12: An access to the bus-master window completes with h_rdata 0, h_err 0 and no device transfer. h_done is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O space enable |
| cfg_we | input | 1 | Base register write strobe |
| cfg_idx | input | 3 | Window index for a base write (0..4) |
| cfg_base | input | AW | New base value |
| dev_present | input | 4 | One bit per attached device |
| h_req | input | 1 | Host request, taken when idle |
| h_we | input | 1 | Host write (1) or read (0) |
| h_size | input | 2 | 0 byte, 1 half-word, 2 word |
| h_addr | input | AW | Host address |
| h_wdata | input | 32 | Host write data |
| h_done | output | 1 | Completion pulse |
| h_err | output | 1 | Error flag, valid with h_done |
| h_rdata | output | 32 | Read data, valid with h_done |
| dec_kind | output | 2 | Window kind of the last accepted request |
| dec_chan | output | 1 | Channel of the last accepted request |
| dec_off | output | OW | Offset of the last accepted request |
| dv_valid | output | 1 | Device transfer valid |
| dv_dev | output | 2 | Target device index |
| dv_we | output | 1 | Device transfer is a write |
| dv_ctl | output | 1 | 1 selects the control block, 0 the command block |
| dv_off | output | OW | Register offset inside the block |
| dv_wdata | output | 16 | Device write data |
| dv_ready | input | 1 | Device accepts the transfer |
| dv_rdata | input | 16 | Device read data, taken with dv_ready |

## Verification
The assertions rely on three assumptions about the inputs. dev_present stays constant while a transfer is open. A device raises dv_ready only while dv_valid is high. The host asserts h_req again only after it has seen h_done. The stimulus follows all three. The device mask is fixed for the whole run, the device model answers only a pending dv_valid after one wait cycle, and the driver waits for each completion before it issues the next request. Base changes are made only between requests, so no request is decoded against a base that is being rewritten.

// File: rtl/pio_route_pkg.sv
package pio_route_pkg;
  localparam int NWIN  = 5;
  localparam int NCHAN = 2;
  localparam int NDEV  = 4;
  localparam int DVW   = 2;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_CMD  = 2'd1,
    WK_CTL  = 2'd2,
    WK_BM   = 2'd3
  } win_kind_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/pio_window_decode.sv
module pio_window_decode
  import pio_route_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 4,
  parameter int CMD_SZ = 8,
  parameter int CTL_SZ = 4,
  parameter int BM_SZ = 16,
  parameter int BM_CH1 = 8,
  parameter logic [AW-1:0] RST_PCMD = 16'h01F0,
  parameter logic [AW-1:0] RST_PCTL = 16'h03F4,
  parameter logic [AW-1:0] RST_SCMD = 16'h0170,
  parameter logic [AW-1:0] RST_SCTL = 16'h0374,
  parameter logic [AW-1:0] RST_BM   = 16'hC000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output win_kind_t     kind,
  output logic          chan,
  output logic [OW-1:0] off
);
  function automatic int win_size(input int i);
    case (i)
      0, 2:    return CMD_SZ;
      1, 3:    return CTL_SZ;
      default: return BM_SZ;
    endcase
  endfunction

  function automatic logic [AW-1:0] win_rst(input int i);
    case (i)
      0:       return RST_PCMD;
      1:       return RST_PCTL;
      2:       return RST_SCMD;
      3:       return RST_SCTL;
      default: return RST_BM;
    endcase
  endfunction

  logic [AW-1:0] base_w [NWIN];
  logic [NWIN-1:0] in_win;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [AW:0] SZ = (AW+1)'(win_size(g));
    logic [AW-1:0] base_r;

    always_ff @(posedge clk) begin
      if (rst) base_r <= win_rst(g);
      else if (cfg_we && cfg_idx == 3'(g) && cfg_base != '0) base_r <= cfg_base;
    end

    assign base_w[g] = base_r;
    assign in_win[g] = (addr >= base_r) && ({1'b0, addr} < ({1'b0, base_r} + SZ));

    // R4: a programmed base is never zero
    p_base_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
      base_r != '0);
  end

  logic [2:0]    pick;
  logic [AW-1:0] pick_base;
  logic [AW-1:0] rel;

  always_comb begin
    hit       = 1'b0;
    pick      = 3'd0;
    pick_base = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit       = 1'b1;
        pick      = 3'(i);
        pick_base = base_w[i];
      end
    end
    rel = addr - pick_base;
    if (!hit) begin
      kind = WK_NONE;
      chan = 1'b0;
      off  = '0;
    end else begin
      off = rel[OW-1:0];
      case (pick)
        3'd0:    begin kind = WK_CMD; chan = 1'b0; end
        3'd1:    begin kind = WK_CTL; chan = 1'b0; end
        3'd2:    begin kind = WK_CMD; chan = 1'b1; end
        3'd3:    begin kind = WK_CTL; chan = 1'b1; end
        default: begin kind = WK_BM;  chan = (rel >= AW'(BM_CH1)); end
      endcase
    end
  end
endmodule

// File: rtl/pio_sel_track.sv
module pio_sel_track
  import pio_route_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_we,
  input  logic           sel_bit,
  input  logic           chan,
  output logic [DVW-1:0] dev_idx
);
  logic [NCHAN-1:0] bit_q;

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) bit_q[c] <= 1'b0;
      else if (sel_we && chan == c[0]) bit_q[c] <= sel_bit;
    end
  end

  logic eff;
  assign eff     = sel_we ? sel_bit : bit_q[chan];
  assign dev_idx = {chan, eff};
endmodule

// File: rtl/pio_route_seq.sv
module pio_route_seq
  import pio_route_pkg::*;
#(
  parameter int OW = 4,
  parameter int HW = 16,
  parameter int SEL_OFF = 6,
  parameter int SEL_BIT = 4,
  localparam int DW = 2 * HW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_en,
  input  logic [NDEV-1:0] dev_present,
  input  logic            h_req,
  input  logic            h_we,
  input  logic [1:0]      h_size,
  input  logic [DW-1:0]   h_wdata,
  output logic            h_done,
  output logic            h_err,
  output logic [DW-1:0]   h_rdata,
  input  logic            win_hit,
  input  win_kind_t       win_kind,
  input  logic            win_chan,
  input  logic [OW-1:0]   win_off,
  input  logic [DVW-1:0]  dev_idx,
  output logic            sel_we,
  output logic            sel_bit,
  output logic [1:0]      dec_kind,
  output logic            dec_chan,
  output logic [OW-1:0]   dec_off,
  output logic            dv_valid,
  output logic [DVW-1:0]  dv_dev,
  output logic            dv_we,
  output logic            dv_ctl,
  output logic [OW-1:0]   dv_off,
  output logic [HW-1:0]   dv_wdata,
  input  logic            dv_ready,
  input  logic [HW-1:0]   dv_rdata
);
  typedef enum logic {S_IDLE, S_XFER} st_t;
  st_t st;

  logic          accept, is_cmd, is_dreg, size_ok;
  logic          two_q, second_q, byte_q;
  logic [HW-1:0] hi_wd_q, lo_rd_q;

  assign accept  = (st == S_IDLE) && h_req && !h_done;
  assign is_cmd  = (win_kind == WK_CMD);
  assign is_dreg = is_cmd && (win_off == '0);
  assign size_ok = is_dreg ? (h_size == SZ_HALF || h_size == SZ_WORD)
                           : (h_size == SZ_BYTE);
  assign sel_we  = accept && io_en && is_cmd && (win_off == OW'(SEL_OFF))
                   && h_we && (h_size == SZ_BYTE);
  assign sel_bit = h_wdata[SEL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      h_done   <= 1'b0;
      h_err    <= 1'b0;
      h_rdata  <= '0;
      dec_kind <= WK_NONE;
      dec_chan <= 1'b0;
      dec_off  <= '0;
      dv_valid <= 1'b0;
      dv_dev   <= '0;
      dv_we    <= 1'b0;
      dv_ctl   <= 1'b0;
      dv_off   <= '0;
      dv_wdata <= '0;
      two_q    <= 1'b0;
      second_q <= 1'b0;
      byte_q   <= 1'b0;
      hi_wd_q  <= '0;
      lo_rd_q  <= '0;
    end else begin
      h_done <= 1'b0;
      h_err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            dec_kind <= win_kind;
            dec_chan <= win_chan;
            dec_off  <= win_off;
            h_rdata  <= '0;
            if (!io_en) begin
              h_done <= 1'b1;
            end else if (!win_hit) begin
              h_done <= 1'b1;
              h_err  <= 1'b1;
            end else if (win_kind == WK_BM) begin
              h_done <= 1'b1;
            end else if (!size_ok) begin
              h_done <= 1'b1;
              h_err  <= 1'b1;
            end else if (!dev_present[dev_idx]) begin
              h_done <= 1'b1;
            end else begin
              dv_valid <= 1'b1;
              dv_dev   <= dev_idx;
              dv_we    <= h_we;
              dv_ctl   <= (win_kind == WK_CTL);
              dv_off   <= win_off;
              dv_wdata <= h_wdata[HW-1:0];
              hi_wd_q  <= h_wdata[DW-1:HW];
              two_q    <= (h_size == SZ_WORD);
              byte_q   <= (h_size == SZ_BYTE);
              second_q <= 1'b0;
              st       <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (dv_ready) begin
            if (two_q && !second_q) begin
              second_q <= 1'b1;
              dv_wdata <= hi_wd_q;
              lo_rd_q  <= dv_rdata;
            end else begin
              dv_valid <= 1'b0;
              second_q <= 1'b0;
              st       <= S_IDLE;
              h_done   <= 1'b1;
              if (!dv_we) begin
                if (two_q)       h_rdata <= {dv_rdata, lo_rd_q};
                else if (byte_q) h_rdata <= DW'(dv_rdata[7:0]);
                else             h_rdata <= DW'(dv_rdata);
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a pending transfer holds its fields until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dv_valid && !dv_ready) |=> (dv_valid && $stable(dv_dev) && $stable(dv_off)
                                 && $stable(dv_wdata) && $stable(dv_we)));
  // R7: transfers only target present devices
  p_present_r7: assert property (@(posedge clk) disable iff (rst)
    dv_valid |-> dev_present[dv_dev]);
  // R5: disabled I/O never starts a transfer
  p_ioen_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !io_en) |=> !dv_valid);
  // R9: the first half of a wide access is followed by a second
  p_split_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_XFER && dv_ready && two_q && !second_q) |=> (dv_valid && !h_done));
  // R10: errors are only reported with completion
  p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
    h_err |-> h_done);
  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    h_done |=> !h_done);
endmodule

// File: rtl/pio_window_router.sv
module pio_window_router
  import pio_route_pkg::*;
#(
  parameter int AW = 16,
  parameter int CMD_SZ = 8,
  parameter int CTL_SZ = 4,
  parameter int BM_SZ = 16,
  parameter int BM_CH1 = 8,
  parameter int SEL_OFF = 6,
  parameter int SEL_BIT = 4,
  parameter int HW = 16,
  parameter logic [AW-1:0] RST_PCMD = 16'h01F0,
  parameter logic [AW-1:0] RST_PCTL = 16'h03F4,
  parameter logic [AW-1:0] RST_SCMD = 16'h0170,
  parameter logic [AW-1:0] RST_SCTL = 16'h0374,
  parameter logic [AW-1:0] RST_BM   = 16'hC000,
  localparam int MAXSZ = (BM_SZ > CMD_SZ) ? ((BM_SZ > CTL_SZ) ? BM_SZ : CTL_SZ)
                                          : ((CMD_SZ > CTL_SZ) ? CMD_SZ : CTL_SZ),
  localparam int OW = (MAXSZ > 1) ? $clog2(MAXSZ) : 1,
  localparam int DW = 2 * HW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_en,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_idx,
  input  logic [AW-1:0]   cfg_base,
  input  logic [NDEV-1:0] dev_present,
  input  logic            h_req,
  input  logic            h_we,
  input  logic [1:0]      h_size,
  input  logic [AW-1:0]   h_addr,
  input  logic [DW-1:0]   h_wdata,
  output logic            h_done,
  output logic            h_err,
  output logic [DW-1:0]   h_rdata,
  output logic [1:0]      dec_kind,
  output logic            dec_chan,
  output logic [OW-1:0]   dec_off,
  output logic            dv_valid,
  output logic [DVW-1:0]  dv_dev,
  output logic            dv_we,
  output logic            dv_ctl,
  output logic [OW-1:0]   dv_off,
  output logic [HW-1:0]   dv_wdata,
  input  logic            dv_ready,
  input  logic [HW-1:0]   dv_rdata
);
  logic           w_hit, w_chan, s_we, s_bit;
  win_kind_t      w_kind;
  logic [OW-1:0]  w_off;
  logic [DVW-1:0] d_idx;

  pio_window_decode #(
    .AW(AW), .OW(OW), .CMD_SZ(CMD_SZ), .CTL_SZ(CTL_SZ), .BM_SZ(BM_SZ),
    .BM_CH1(BM_CH1), .RST_PCMD(RST_PCMD), .RST_PCTL(RST_PCTL),
    .RST_SCMD(RST_SCMD), .RST_SCTL(RST_SCTL), .RST_BM(RST_BM)
  ) u_dec (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .addr(h_addr), .hit(w_hit), .kind(w_kind),
    .chan(w_chan), .off(w_off)
  );

  pio_sel_track u_sel (
    .clk(clk), .rst(rst), .sel_we(s_we), .sel_bit(s_bit),
    .chan(w_chan), .dev_idx(d_idx)
  );

  pio_route_seq #(
    .OW(OW), .HW(HW), .SEL_OFF(SEL_OFF), .SEL_BIT(SEL_BIT)
  ) u_seq (
    .clk(clk), .rst(rst), .io_en(io_en), .dev_present(dev_present),
    .h_req(h_req), .h_we(h_we), .h_size(h_size), .h_wdata(h_wdata),
    .h_done(h_done), .h_err(h_err), .h_rdata(h_rdata),
    .win_hit(w_hit), .win_kind(w_kind), .win_chan(w_chan), .win_off(w_off),
    .dev_idx(d_idx), .sel_we(s_we), .sel_bit(s_bit),
    .dec_kind(dec_kind), .dec_chan(dec_chan), .dec_off(dec_off),
    .dv_valid(dv_valid), .dv_dev(dv_dev), .dv_we(dv_we), .dv_ctl(dv_ctl),
    .dv_off(dv_off), .dv_wdata(dv_wdata), .dv_ready(dv_ready),
    .dv_rdata(dv_rdata)
  );
endmodule

// File: tb/sim_pio_window_router.sv
`timescale 1ns/1ps
module sim_pio_window_router;
  logic        clk = 1'b0;
  logic        rst, io_en, cfg_we, h_req, h_we, dv_ready;
  logic [2:0]  cfg_idx;
  logic [15:0] cfg_base, h_addr, dv_rdata, dv_wdata;
  logic [3:0]  dev_present, dec_off, dv_off;
  logic [1:0]  h_size, dec_kind, dv_dev;
  logic [31:0] h_wdata, h_rdata;
  logic        h_done, h_err, dec_chan, dv_valid, dv_we, dv_ctl;

  always #2 clk = ~clk;

  pio_window_router u0 (
    .clk(clk), .rst(rst), .io_en(io_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .dev_present(dev_present), .h_req(h_req), .h_we(h_we),
    .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata), .h_done(h_done),
    .h_err(h_err), .h_rdata(h_rdata), .dec_kind(dec_kind), .dec_chan(dec_chan),
    .dec_off(dec_off), .dv_valid(dv_valid), .dv_dev(dv_dev), .dv_we(dv_we),
    .dv_ctl(dv_ctl), .dv_off(dv_off), .dv_wdata(dv_wdata), .dv_ready(dv_ready),
    .dv_rdata(dv_rdata)
  );

  typedef struct {
    logic [31:0] rd;
    logic        err;
    int          ntx;
    logic [1:0]  kind;
    logic        chan;
    logic [3:0]  off;
  } exp_t;

  exp_t        sbq[$];
  string       tagq[$];
  logic [15:0] wlog_d[$];
  logic [1:0]  wlog_dev[$];
  int checks = 0, errors = 0, txn_cnt = 0, done_cnt = 0;

  function automatic logic [15:0] devword(logic [1:0] d, logic [3:0] o, int half);
    return {(half != 0) ? 4'h5 : 4'hA, 2'b00, d, 4'h0, o};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // device model and scoreboard monitor
  initial begin
    int   wait_c, half;
    logic [3:0] off0;
    exp_t e;
    string t;
    wait_c = 0; half = 0; off0 = '0;
    dv_ready = 1'b0; dv_rdata = '0;
    forever begin
      @(negedge clk);
      dv_ready = 1'b0;
      if (h_done) begin
        if (sbq.size() == 0) begin
          chk("R12 unexpected completion", 32'd1, 32'd0);
        end else begin
          e = sbq.pop_front();
          t = tagq.pop_front();
          chk({t, " rdata"}, h_rdata, e.rd);
          chk({t, " err"}, 32'(h_err), 32'(e.err));
          chk({t, " transfers"}, 32'(txn_cnt), 32'(e.ntx));
          chk({t, " decode"}, {25'd0, e.kind, e.chan, e.off}, {25'd0, dec_kind, dec_chan, dec_off});
        end
        done_cnt++;
        txn_cnt = 0;
        half = 0;
      end
      if (dv_valid) begin
        if (wait_c == 0) begin
          off0 = dv_off;
          wait_c = 1;
        end else begin
          chk("R8 offset held while waiting", 32'(dv_off), 32'(off0));
          dv_ready = 1'b1;
          dv_rdata = devword(dv_dev, dv_off, half);
          if (dv_we) begin
            wlog_d.push_back(dv_wdata);
            wlog_dev.push_back(dv_dev);
          end
          txn_cnt++;
          half++;
          wait_c = 0;
        end
      end
    end
  end

  task automatic access(string tag, logic [15:0] a, logic we, logic [1:0] sz,
                        logic [31:0] wd, logic [31:0] erd, logic eerr, int entx,
                        logic [1:0] ek, logic ech, logic [3:0] eoff);
    exp_t e;
    int d0;
    e.rd = erd; e.err = eerr; e.ntx = entx; e.kind = ek; e.chan = ech; e.off = eoff;
    sbq.push_back(e);
    tagq.push_back(tag);
    d0 = done_cnt;
    @(negedge clk);
    h_addr = a; h_we = we; h_size = sz; h_wdata = wd; h_req = 1'b1;
    @(negedge clk);
    h_req = 1'b0;
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic set_base(logic [2:0] idx, logic [15:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_base = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; io_en = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0;
    dev_present = 4'b0111; h_req = 1'b0; h_we = 1'b0; h_size = '0;
    h_addr = '0; h_wdata = '0;
    repeat (4) @(negedge clk);
    chk("reset h_done", 32'(h_done), 32'd0);
    chk("reset dv_valid", 32'(dv_valid), 32'd0);
    chk("R1 reset dec_kind", 32'(dec_kind), 32'd0);
    rst = 1'b0;

    access("R5 io off read", 16'h01F0, 0, 2'd1, 0, 32'h0, 0, 0, 2'd1, 0, 4'd0);
    io_en = 1'b1;
    access("R9 half data read", 16'h01F0, 0, 2'd1, 0, 32'h0000A000, 0, 1, 2'd1, 0, 4'd0);
    access("R9 word data read", 16'h01F0, 0, 2'd2, 0, 32'h5000A000, 0, 2, 2'd1, 0, 4'd0);

    wlog_d.delete(); wlog_dev.delete();
    access("R6 select dev1 write", 16'h01F6, 1, 2'd0, 32'h10, 32'h0, 0, 1, 2'd1, 0, 4'd6);
    chk("R7 select write goes to new device", 32'(wlog_dev[0]), 32'd1);
    chk("R6 select write data", 32'(wlog_d[0]), 32'h0010);
    access("R7 byte read dev1", 16'h01F7, 0, 2'd0, 0, 32'h07, 0, 1, 2'd1, 0, 4'd7);
    access("R1 control window read", 16'h03F6, 0, 2'd0, 0, 32'h02, 0, 1, 2'd2, 0, 4'd2);
    access("R1 control lower edge miss", 16'h03F3, 0, 2'd0, 0, 32'h0, 1, 0, 2'd0, 0, 4'd0);

    access("R7 select absent dev3", 16'h0176, 1, 2'd0, 32'h10, 32'h0, 0, 0, 2'd1, 1, 4'd6);
    access("R7 absent device read", 16'h0170, 0, 2'd1, 0, 32'h0, 0, 0, 2'd1, 1, 4'd0);
    access("R6 select dev2", 16'h0176, 1, 2'd0, 32'h00, 32'h0, 0, 1, 2'd1, 1, 4'd6);
    access("R7 secondary dev2 read", 16'h0170, 0, 2'd1, 0, 32'h0000A200, 0, 1, 2'd1, 1, 4'd0);

    access("R10 byte data reg", 16'h01F0, 0, 2'd0, 0, 32'h0, 1, 0, 2'd1, 0, 4'd0);
    access("R10 half on byte reg", 16'h01F7, 0, 2'd1, 0, 32'h0, 1, 0, 2'd1, 0, 4'd7);
    access("R10 half select write", 16'h01F6, 1, 2'd1, 0, 32'h0, 1, 0, 2'd1, 0, 4'd6);
    access("R10 select unchanged", 16'h01F0, 0, 2'd1, 0, 32'h0000A100, 0, 1, 2'd1, 0, 4'd0);
    access("R11 miss", 16'h0100, 0, 2'd0, 0, 32'h0, 1, 0, 2'd0, 0, 4'd0);

    access("R3 bm ch0", 16'hC003, 0, 2'd0, 0, 32'h0, 0, 0, 2'd3, 0, 4'd3);
    access("R3 bm ch1 start", 16'hC008, 0, 2'd0, 0, 32'h0, 0, 0, 2'd3, 1, 4'd8);
    access("R12 bm last", 16'hC00F, 1, 2'd2, 32'hFFFF, 32'h0, 0, 0, 2'd3, 1, 4'd15);
    access("R1 bm upper edge miss", 16'hC010, 0, 2'd0, 0, 32'h0, 1, 0, 2'd0, 0, 4'd0);

    set_base(3'd4, 16'h0000);
    access("R4 zero base ignored", 16'hC000, 0, 2'd0, 0, 32'h0, 0, 0, 2'd3, 0, 4'd0);
    set_base(3'd4, 16'hD000);
    access("R4 old base gone", 16'hC000, 0, 2'd0, 0, 32'h0, 1, 0, 2'd0, 0, 4'd0);
    access("R4 new base hit", 16'hD009, 0, 2'd0, 0, 32'h0, 0, 0, 2'd3, 1, 4'd9);

    set_base(3'd2, 16'h01F0);
    access("R2 primary wins overlap", 16'h01F0, 0, 2'd1, 0, 32'h0000A100, 0, 1, 2'd1, 0, 4'd0);

    wlog_d.delete(); wlog_dev.delete();
    access("R9 word data write", 16'h01F0, 1, 2'd2, 32'h1234ABCD, 32'h0, 0, 2, 2'd1, 0, 4'd0);
    chk("R9 split write count", 32'(wlog_d.size()), 32'd2);
    chk("R9 low half first", 32'(wlog_d[0]), 32'h0000ABCD);
    chk("R9 high half second", 32'(wlog_d[1]), 32'h00001234);

    io_en = 1'b0;
    access("R5 io off select write", 16'h01F6, 1, 2'd0, 32'h00, 32'h0, 0, 0, 2'd1, 0, 4'd6);
    io_en = 1'b1;
    access("R5 select kept", 16'h01F0, 0, 2'd1, 0, 32'h0000A100, 0, 1, 2'd1, 0, 4'd0);

    repeat (4) @(negedge clk);
    chk("R12 scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule